// File: doc/BRIEF.md
# Trap Return and Global Bank Select

This block restores the architectural state when a trap handler finishes, for a 64-bit processor with register windows and a stack of trap levels. A return strobe carries one of two kinds: one finishes the trapped instruction and moves on (complete), and the other runs the trapped instruction again (reissue). When the strobe arrives, the trap-state storage outside the block presents the saved PC, the saved next-PC and a packed saved-state word for the current trap level. In one clock the block loads the program counters, the condition codes, the address-space identifier, the processor-state word and the window pointer from these values, and lowers the trap level by one.

The block also tracks which of four global register banks is active: normal, alternate, MMU or interrupt. It derives the bank from three bits of the processor-state word. It pulses an indication whenever the bank selector changes, so that a register file elsewhere can swap its contents. Software can also write the processor-state word directly. Trap entry code can load the trap level. A build option removes alternate-bank support.

Top module: `trap_return_unit`

## Requirements
- R1: After reset, pc is 0, npc is 4, xcc, icc, asi, pstate and wp are 0, tl equals MAX_TL, gbank is 0 (normal), and bank_switch and ret_illegal are low.
- R2: A complete return (ret_kind = 0) accepted at tl > 0 loads pc with sv_npc and npc with sv_npc + 4, modulo 2^AW. The new values are visible after the capturing edge.
- R3: A reissue return (ret_kind = 1) accepted at tl > 0 loads pc with sv_pc and npc with sv_npc.
- R4: An accepted return takes xcc from sv_tstate[39:36], icc from sv_tstate[35:32], asi from sv_tstate[31:24] and pstate from sv_tstate[19:8] ANDed with 12'hF3F. It sets wp to sv_tstate[7:0] modulo NWIN. Bits 23:20 have no effect.
- R5: Each accepted return lowers tl by exactly one.
- R6: gbank follows the selector {pstate[11], pstate[10], pstate[0]}. 000 gives 0 (normal), 001 gives 1 (alternate), 010 gives 2 (MMU) and 100 gives 3 (interrupt). Every other selector value gives 0.
- R7: With NO_ALT = 1, bit 0 of every new processor-state value is cleared before it is stored and before the bank is selected.
- R8: bank_switch is high for the one cycle after a processor-state update whose 3-bit selector differs from the previous selector. It is low after an update with the same selector and in every other cycle.
- R9: A direct write (pst_wr_valid) stores pst_wr_data ANDed with 12'hF3F as pstate, and the bank is then updated as in R6 to R8.
- R10: A return at tl = 0 raises ret_illegal for one cycle and changes no other output.
- R11: ret_valid takes priority over pst_wr_valid, which takes priority over tl_set_valid. A lower-priority request in the same cycle is dropped. This holds even when the return is illegal.
- R12: A tl_set_valid load stores min(tl_set_val, MAX_TL) into tl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Return strobe |
| ret_kind | input | 1 | 0 = complete, 1 = reissue |
| sv_pc | input | AW | Saved PC for the current trap level |
| sv_npc | input | AW | Saved next-PC for the current trap level |
| sv_tstate | input | 40 | Packed saved-state word |
| pst_wr_valid | input | 1 | Direct processor-state write strobe |
| pst_wr_data | input | 12 | Direct processor-state write value |
| tl_set_valid | input | 1 | Trap level load strobe |
| tl_set_val | input | TL_W | Trap level load value |
| pc | output | AW | Program counter |
| npc | output | AW | Next program counter |
| xcc | output | 4 | Extended (64-bit) condition codes |
| icc | output | 4 | Integer (32-bit) condition codes |
| asi | output | 8 | Address-space identifier |
| pstate | output | 12 | Processor-state word |
| wp | output | WP_W | Window pointer |
| tl | output | TL_W | Trap level |
| gbank | output | 2 | Active global bank |
| bank_switch | output | 1 | Pulse: the bank selector changed |
| ret_illegal | output | 1 | Pulse: a return was issued at trap level 0 |

## Verification
The assertions rely on the saved PC, next-PC and state word being valid in the same cycle as the return strobe. They also assume that every strobe lasts exactly one clock. The stimulus changes all inputs on the falling edge and holds each request for a single cycle. It always supplies saved values together with the strobe. Trap level loads are used to reach trap level 0 on purpose and to recover from it, so that illegal returns occur only where the bench plans them.

// File: rtl/trp_pkg.sv
package trp_pkg;

  typedef enum logic [1:0] {
    GB_NORMAL = 2'd0,
    GB_ALT    = 2'd1,
    GB_MMU    = 2'd2,
    GB_INTR   = 2'd3
  } gbank_e;

  localparam logic [11:0] PST_KEEP = 12'hF3F;

  typedef struct packed {
    logic [7:0]  ccr;
    logic [7:0]  asi;
    logic [11:0] pst;
    logic [7:0]  wp;
  } tsf_t;

  // pull the restored fields out of the packed saved-state word
  function automatic tsf_t split_tstate(input logic [39:0] w);
    tsf_t r;
    r.ccr = w[39:32];
    r.asi = w[31:24];
    r.pst = w[19:8] & PST_KEEP;
    r.wp  = w[7:0];
    return r;
  endfunction

  function automatic logic [2:0] bank_sel_bits(input logic [11:0] p);
    return {p[11], p[10], p[0]};
  endfunction

  function automatic gbank_e bank_of(input logic [2:0] s);
    case (s)
      3'b001:  return GB_ALT;
      3'b010:  return GB_MMU;
      3'b100:  return GB_INTR;
      default: return GB_NORMAL;
    endcase
  endfunction

  function automatic logic [7:0] wrap_wp(input logic [7:0] v, input int unsigned n);
    int unsigned t;
    t = 32'(v) % n;
    return t[7:0];
  endfunction

endpackage

// File: rtl/trp_field_unpack.sv
module trp_field_unpack
  import trp_pkg::*;
#(
  parameter int AW   = 64,
  parameter int NWIN = 8,
  parameter int WP_W = $clog2(NWIN)
) (
  input  logic            kind,
  input  logic [AW-1:0]   sv_pc,
  input  logic [AW-1:0]   sv_npc,
  input  logic [39:0]     sv_tstate,
  output logic [AW-1:0]   nxt_pc,
  output logic [AW-1:0]   nxt_npc,
  output logic [3:0]      nxt_xcc,
  output logic [3:0]      nxt_icc,
  output logic [7:0]      nxt_asi,
  output logic [11:0]     nxt_pst,
  output logic [WP_W-1:0] nxt_wp
);
  localparam logic [AW-1:0] STEP = {{(AW-3){1'b0}}, 3'd4};

  tsf_t       f;
  logic [7:0] w_mod;

  always_comb begin
    f       = split_tstate(sv_tstate);
    w_mod   = wrap_wp(f.wp, NWIN);
    nxt_xcc = f.ccr[7:4];
    nxt_icc = f.ccr[3:0];
    nxt_asi = f.asi;
    nxt_pst = f.pst;
    nxt_wp  = w_mod[WP_W-1:0];
    if (kind) begin
      nxt_pc  = sv_pc;
      nxt_npc = sv_npc;
    end else begin
      nxt_pc  = sv_npc;
      nxt_npc = sv_npc + STEP;
    end
  end
endmodule

// File: rtl/trp_bank_select.sv
module trp_bank_select
  import trp_pkg::*;
#(
  parameter bit NO_ALT = 1'b0
) (
  input  logic [11:0] pst_in,
  output logic [11:0] pst_out,
  output logic [2:0]  sel,
  output logic [1:0]  bank
);
  generate
    if (NO_ALT) begin : g_noalt
      assign pst_out = {pst_in[11:1], 1'b0};
    end else begin : g_alt
      assign pst_out = pst_in;
    end
  endgenerate

  assign sel  = bank_sel_bits(pst_out);
  assign bank = bank_of(sel);
endmodule

// File: rtl/trp_level_ctl.sv
module trp_level_ctl #(
  parameter int MAX_TL = 6,
  parameter int TL_W   = $clog2(MAX_TL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_valid,
  input  logic            pst_wr_valid,
  input  logic            tl_set_valid,
  input  logic [TL_W-1:0] tl_set_val,
  output logic [TL_W-1:0] tl,
  output logic            ret_ok,
  output logic            ret_illegal
);
  localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);

  logic [TL_W-1:0] tl_q;
  logic            ill_q;
  logic            set_take;

  assign ret_ok   = ret_valid && (tl_q != '0);
  assign set_take = tl_set_valid && !ret_valid && !pst_wr_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl_q  <= TL_TOP;
      ill_q <= 1'b0;
    end else begin
      ill_q <= ret_valid && (tl_q == '0);
      if (ret_ok)
        tl_q <= tl_q - 1'b1;
      else if (set_take)
        tl_q <= (tl_set_val > TL_TOP) ? TL_TOP : tl_set_val;
    end
  end

  assign tl          = tl_q;
  assign ret_illegal = ill_q;

  // R5: an accepted return steps the level down by one
  a_r5_tl_step: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> tl_q == $past(tl_q) - 1'b1);

  // R10: a return at level 0 is flagged and leaves the level alone
  a_r10_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && tl_q == '0) |=> (ill_q && tl_q == '0));

  // R12: the level never exceeds its ceiling
  a_r12_tl_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    tl_q <= TL_TOP);

  // R11: a level load under a return or state write is dropped
  a_r11_set_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (tl_set_valid && pst_wr_valid && !ret_valid) |=> $stable(tl_q));
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter int AW     = 64,
  parameter int NWIN   = 8,
  parameter int MAX_TL = 6,
  parameter bit NO_ALT = 1'b0,
  parameter int WP_W   = $clog2(NWIN),
  parameter int TL_W   = $clog2(MAX_TL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_valid,
  input  logic            ret_kind,
  input  logic [AW-1:0]   sv_pc,
  input  logic [AW-1:0]   sv_npc,
  input  logic [39:0]     sv_tstate,
  input  logic            pst_wr_valid,
  input  logic [11:0]     pst_wr_data,
  input  logic            tl_set_valid,
  input  logic [TL_W-1:0] tl_set_val,
  output logic [AW-1:0]   pc,
  output logic [AW-1:0]   npc,
  output logic [3:0]      xcc,
  output logic [3:0]      icc,
  output logic [7:0]      asi,
  output logic [11:0]     pstate,
  output logic [WP_W-1:0] wp,
  output logic [TL_W-1:0] tl,
  output logic [1:0]      gbank,
  output logic            bank_switch,
  output logic            ret_illegal
);
  localparam logic [AW-1:0] NPC_RST = {{(AW-3){1'b0}}, 3'd4};

  // named internal events
  logic            ret_ok;
  logic            pst_upd;
  logic [11:0]     pst_src;
  logic [11:0]     pst_new;
  logic [2:0]      sel_new;
  logic [1:0]      bank_new;

  logic [AW-1:0]   u_pc, u_npc;
  logic [3:0]      u_xcc, u_icc;
  logic [7:0]      u_asi;
  logic [11:0]     u_pst;
  logic [WP_W-1:0] u_wp;

  logic [AW-1:0]   pc_q, npc_q;
  logic [3:0]      xcc_q, icc_q;
  logic [7:0]      asi_q;
  logic [11:0]     pst_q;
  logic [WP_W-1:0] wp_q;
  logic [2:0]      sel_q;
  logic [1:0]      bank_q;
  logic            sw_q;

  trp_level_ctl #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_lvl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ret_valid    (ret_valid),
    .pst_wr_valid (pst_wr_valid),
    .tl_set_valid (tl_set_valid),
    .tl_set_val   (tl_set_val),
    .tl           (tl),
    .ret_ok       (ret_ok),
    .ret_illegal  (ret_illegal)
  );

  trp_field_unpack #(.AW(AW), .NWIN(NWIN), .WP_W(WP_W)) u_unp (
    .kind      (ret_kind),
    .sv_pc     (sv_pc),
    .sv_npc    (sv_npc),
    .sv_tstate (sv_tstate),
    .nxt_pc    (u_pc),
    .nxt_npc   (u_npc),
    .nxt_xcc   (u_xcc),
    .nxt_icc   (u_icc),
    .nxt_asi   (u_asi),
    .nxt_pst   (u_pst),
    .nxt_wp    (u_wp)
  );

  assign pst_upd = ret_ok || (pst_wr_valid && !ret_valid);
  assign pst_src = ret_ok ? u_pst : (pst_wr_data & PST_KEEP);

  trp_bank_select #(.NO_ALT(NO_ALT)) u_bank (
    .pst_in  (pst_src),
    .pst_out (pst_new),
    .sel     (sel_new),
    .bank    (bank_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      npc_q  <= NPC_RST;
      xcc_q  <= '0;
      icc_q  <= '0;
      asi_q  <= '0;
      pst_q  <= '0;
      wp_q   <= '0;
      sel_q  <= '0;
      bank_q <= GB_NORMAL;
      sw_q   <= 1'b0;
    end else begin
      sw_q <= 1'b0;
      if (ret_ok) begin
        pc_q  <= u_pc;
        npc_q <= u_npc;
        xcc_q <= u_xcc;
        icc_q <= u_icc;
        asi_q <= u_asi;
        wp_q  <= u_wp;
      end
      if (pst_upd) begin
        pst_q  <= pst_new;
        sel_q  <= sel_new;
        bank_q <= bank_new;
        sw_q   <= (sel_new != sel_q);
      end
    end
  end

  assign pc          = pc_q;
  assign npc         = npc_q;
  assign xcc         = xcc_q;
  assign icc         = icc_q;
  assign asi         = asi_q;
  assign pstate      = pst_q;
  assign wp          = wp_q;
  assign gbank       = bank_q;
  assign bank_switch = sw_q;

  // R2: a complete return moves npc four bytes past the saved next-PC
  a_r2_complete_npc: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_ok && !ret_kind) |=> (npc_q == $past(sv_npc) + NPC_RST && pc_q == $past(sv_npc)));

  // R3: a reissue return takes both counters unchanged
  a_r3_reissue_pcs: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_ok && ret_kind) |=> (pc_q == $past(sv_pc) && npc_q == $past(sv_npc)));

  // R4: the window pointer stays inside the window count
  a_r4_wp_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(wp_q) < NWIN);

  // R6: the alternate bank is only active with state bit 0 set
  a_r6_alt_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q == GB_ALT) |-> pst_q[0]);

  // R8: a switch pulse always reflects a selector change
  a_r8_switch_real: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q |-> (sel_q != $past(sel_q)));

  // R9: masked bits never reach the stored state word
  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    pst_q[7:6] == 2'b00);

  // R10: an illegal return leaves the restored state untouched
  a_r10_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    ret_illegal |-> ($stable(pc_q) && $stable(npc_q) && $stable(pst_q) && $stable(wp_q) && !sw_q));

  generate
    if (NO_ALT) begin : g_chk_noalt
      // R7: with the option on, bit 0 is never stored
      a_r7_no_alt_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !pst_q[0] && bank_q != GB_ALT);
    end
  endgenerate
endmodule

// File: tb/sim_trap_return_unit.sv
`timescale 1ns/1ps
module sim_trap_return_unit;
  localparam int AW = 64, NW = 6, MT = 6, TW = 3, WW = 3;
  localparam int IW = 191;

  typedef struct {
    logic [IW-1:0] v;
    string         tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          ret_valid = 0, ret_kind = 0, pst_wr_valid = 0, tl_set_valid = 0;
  logic [63:0]   sv_pc = '0, sv_npc = '0;
  logic [39:0]   sv_tstate = '0;
  logic [11:0]   pst_wr_data = '0;
  logic [TW-1:0] tl_set_val = '0;

  logic [63:0] pc, npc; logic [3:0] xcc, icc; logic [7:0] asi; logic [11:0] pstate, pstate1;
  logic [WW-1:0] wp, wp1; logic [TW-1:0] tl, tl1; logic [1:0] gbank, gbank1;
  logic bank_switch, bank_switch1, ret_illegal, ret_illegal1;
  logic [63:0] pc1, npc1; logic [3:0] xcc1, icc1; logic [7:0] asi1;

  trap_return_unit #(.AW(AW), .NWIN(NW), .MAX_TL(MT), .NO_ALT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind), .sv_pc(sv_pc),
    .sv_npc(sv_npc), .sv_tstate(sv_tstate), .pst_wr_valid(pst_wr_valid), .pst_wr_data(pst_wr_data),
    .tl_set_valid(tl_set_valid), .tl_set_val(tl_set_val), .pc(pc), .npc(npc), .xcc(xcc), .icc(icc),
    .asi(asi), .pstate(pstate), .wp(wp), .tl(tl), .gbank(gbank), .bank_switch(bank_switch),
    .ret_illegal(ret_illegal));

  trap_return_unit #(.AW(AW), .NWIN(NW), .MAX_TL(MT), .NO_ALT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind), .sv_pc(sv_pc),
    .sv_npc(sv_npc), .sv_tstate(sv_tstate), .pst_wr_valid(pst_wr_valid), .pst_wr_data(pst_wr_data),
    .tl_set_valid(tl_set_valid), .tl_set_val(tl_set_val), .pc(pc1), .npc(npc1), .xcc(xcc1), .icc(icc1),
    .asi(asi1), .pstate(pstate1), .wp(wp1), .tl(tl1), .gbank(gbank1), .bank_switch(bank_switch1),
    .ret_illegal(ret_illegal1));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  item_t sb[$];

  // bench-side reference state
  logic [63:0] m_pc, m_npc; logic [3:0] m_xcc, m_icc; logic [7:0] m_asi;
  logic [11:0] m_pst, m_pst1; int m_wp, m_tl; logic [2:0] m_sel, m_sel1;

  function automatic logic [1:0] ref_bank(input logic [2:0] s);
    if (s == 3'b001) return 2'd1;
    if (s == 3'b010) return 2'd2;
    if (s == 3'b100) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [39:0] mk_ts(input logic [7:0] cc, input logic [7:0] a,
                                        input logic [11:0] p, input logic [7:0] w);
    return {cc, a, 4'hF, p, w};
  endfunction

  function automatic logic [IW-1:0] seen();
    return {pc, npc, xcc, icc, asi, pstate, 8'(wp), 8'(tl), gbank, bank_switch, ret_illegal,
            pstate1, gbank1, bank_switch1};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [IW-1:0] a, input logic [IW-1:0] e);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic op(input bit r, input bit k, input logic [63:0] spc, input logic [63:0] snpc,
                    input logic [39:0] sts, input bit pw, input logic [11:0] pwd,
                    input bit tsv, input logic [TW-1:0] tsval, input string tag);
    bit ill = 0, sw = 0, sw1 = 0;
    logic [11:0] p, p1; logic [2:0] s, s1;
    item_t it;
    bit upd = 0;
    @(negedge clk);
    ret_valid = r; ret_kind = k; sv_pc = spc; sv_npc = snpc; sv_tstate = sts;
    pst_wr_valid = pw; pst_wr_data = pwd; tl_set_valid = tsv; tl_set_val = tsval;
    p = '0;
    if (r) begin
      if (m_tl == 0) ill = 1;
      else begin
        m_pc  = k ? spc : snpc;
        m_npc = k ? snpc : snpc + 64'd4;
        m_xcc = sts[39:36]; m_icc = sts[35:32]; m_asi = sts[31:24];
        m_wp  = int'(sts[7:0]) % NW;
        m_tl  = m_tl - 1;
        p = sts[19:8] & 12'hF3F; upd = 1;
      end
    end else if (pw) begin
      p = pwd & 12'hF3F; upd = 1;
    end else if (tsv) begin
      m_tl = (int'(tsval) > MT) ? MT : int'(tsval);
    end
    if (upd) begin
      s = {p[11], p[10], p[0]};     sw = (s != m_sel);   m_sel = s;   m_pst = p;
      p1 = p & 12'hFFE;
      s1 = {p1[11], p1[10], 1'b0};  sw1 = (s1 != m_sel1); m_sel1 = s1; m_pst1 = p1;
    end
    it.v = {m_pc, m_npc, m_xcc, m_icc, m_asi, m_pst, 8'(m_wp), 8'(m_tl), ref_bank(m_sel), sw, ill,
            m_pst1, ref_bank(m_sel1), sw1};
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    ret_valid = 0; pst_wr_valid = 0; tl_set_valid = 0;
  endtask

  // monitor: compare after each capturing edge that has a pending expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t got;
        got = sb.pop_front();
        check(seen() === got.v, got.tag, seen(), got.v);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    m_pc = '0; m_npc = 64'd4; m_xcc = '0; m_icc = '0; m_asi = '0; m_pst = '0; m_pst1 = '0;
    m_wp = 0; m_tl = MT; m_sel = '0; m_sel1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(seen() === {64'd0, 64'd4, 4'd0, 4'd0, 8'd0, 12'd0, 8'd0, 8'(MT), 2'd0, 1'b0, 1'b0, 12'd0, 2'd0, 1'b0},
          "R1 reset", seen(), {64'd0, 64'd4, 4'd0, 4'd0, 8'd0, 12'd0, 8'd0, 8'(MT), 2'd0, 1'b0, 1'b0, 12'd0, 2'd0, 1'b0});

    // R2 R4 R5 R6 R7 R8: complete return into the alternate bank, wp 9 mod 6
    op(1, 0, 64'h1000, 64'h2000, mk_ts(8'hA5, 8'h80, 12'h001, 8'd9), 0, 0, 0, 0, "R2_R4_R6_R7");
    // R3 R4 R9: reissue, state bits masked, fallback selector 111 -> normal
    op(1, 1, 64'h3000, 64'h3004, mk_ts(8'h3C, 8'h11, 12'hFFF, 8'd200), 0, 0, 0, 0, "R3_R4_R5");
    // R9 R6: direct write selects MMU
    op(0, 0, 0, 0, 0, 1, 12'h400, 0, 0, "R9_mmu");
    // R8: same selector, no pulse
    op(0, 0, 0, 0, 0, 1, 12'h430, 0, 0, "R8_same_sel");
    // R9 R6: interrupt bank, bits 7:6 dropped
    op(0, 0, 0, 0, 0, 1, 12'h8C0, 0, 0, "R9_intr");
    // R7: alternate request is removed in the option variant
    op(0, 0, 0, 0, 0, 1, 12'h001, 0, 0, "R7_alt_write");
    // R11: return wins over simultaneous write
    op(1, 1, 64'h4000, 64'h4008, mk_ts(8'h00, 8'h22, 12'h000, 8'd5), 1, 12'h400, 0, 0, "R11_ret_over_wr");
    // R12: clamp above ceiling
    op(0, 0, 0, 0, 0, 0, 0, 1, 3'd7, "R12_clamp");
    // R11: level load dropped under a write
    op(0, 0, 0, 0, 0, 1, 12'h800, 1, 3'd2, "R11_wr_over_set");
    op(0, 0, 0, 0, 0, 0, 0, 1, 3'd1, "R12_set_one");
    op(1, 0, 64'h5000, 64'h6000, mk_ts(8'h77, 8'h33, 12'h401, 8'd3), 0, 0, 0, 0, "R5_to_zero");
    // R10: return at level zero
    op(1, 0, 64'h7000, 64'h8000, mk_ts(8'hFF, 8'hFF, 12'h001, 8'd1), 0, 0, 0, 0, "R10_illegal");
    // R10 R11: illegal reissue still blocks the write
    op(1, 1, 64'h7000, 64'h8000, mk_ts(8'h11, 8'h11, 12'h000, 8'd2), 1, 12'h001, 0, 0, "R10_R11_illegal_wr");
    op(0, 0, 0, 0, 0, 0, 0, 1, 3'd3, "R12_set_three");
    // R2: next-PC wraps at the top of the address space
    op(1, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, mk_ts(8'h12, 8'h34, 12'h000, 8'd255), 0, 0, 0, 0, "R2_wrap");

    lf = 32'hACE1_2345;
    for (int i = 0; i < 30; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      if (m_tl == 0)
        op(0, 0, 0, 0, 0, 0, 0, 1, 3'(lf[2:0]), "R12_mix");
      else if (lf[3])
        op(0, 0, 0, 0, 0, 1, lf[15:4], 0, 0, "R9_mix");
      else
        op(1, lf[4], {lf, lf ^ 32'h5A5A}, {lf ^ 32'h1234, lf}, {lf[31:0], lf[7:0] ^ 8'hC3},
           0, 0, 0, 0, lf[4] ? "R3_mix" : "R2_mix");
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule